// File: doc/BRIEF.md
# ATM Alarm Cell Slot Selector

This block picks the content of every outgoing cell slot on an ATM link that can be in alarm. A classifier upstream reports each incoming cell as a regular user cell, an empty cell or an alarm indication (AIS) maintenance cell. A cell buffer reports whether it holds a cell ready to transmit. For every transmit slot the block answers with a 2-bit choice: forward the buffered cell, insert an AIS cell, or fill the slot with an empty cell.

The block has two states. In the normal state, buffered cells go out whenever one is ready and empty filler cells go out otherwise. An AIS arrival switches the block to the alarm state. In that state one AIS cell goes out in the first slot. After that, a fresh AIS cell is inserted once per `PERIOD` buffered cells sent, and buffered cells keep flowing in between. The first regular user cell that arrives returns the block to the normal state. Empty arrivals never change anything, because the filler on the output is generated locally.

Top module: `ais_cell_steer`

## Requirements
- R1: While `rst` is high on a clock edge, the block clears `slot_valid` and `alarm_state`, clears the insertion counter and drops any pending insertion.
- R2: `slot_valid` is high exactly in the cycle after a cycle with `slot_tick` high. `slot_sel` is then 2'b00 for an empty filler, 2'b01 for the buffered cell and 2'b10 for an AIS cell, and never 2'b11.
- R3: In the normal state a slot carries the buffered cell (01) when `buf_ready` is high and an empty filler (00) when it is low.
- R4: An arrival with `in_valid` high and `in_kind` 2'b10 (AIS) sets `alarm_state` at the next edge. The first slot after that carries an AIS cell (10), even when `buf_ready` is low, and loads the counter with `PERIOD`.
- R5: In the alarm state, each buffered cell sent decrements the counter, and filler slots do not. When `PERIOD` buffered cells have been sent since the last AIS cell, the next slot carries an AIS cell and the counter reloads.
- R6: A pending AIS insertion takes the slot even when `buf_ready` is high, and the buffered cell waits for a later slot.
- R7: An arrival with `in_kind` 2'b00 (regular user cell) clears `alarm_state` at the next edge and cancels any pending or counted insertion.
- R8: Arrivals with `in_kind` 2'b01 (empty cell) or 2'b11 (unused code) change neither the state nor the counter, so the slot choices that follow are the same as without them.
- R9: When an arrival and `slot_tick` fall in the same cycle, the slot is decided by the state held before the arrival.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A classified arrival is presented this cycle |
| in_kind | input | 2 | Arrival class: 00 regular, 01 empty, 10 AIS, 11 unused |
| buf_ready | input | 1 | Output buffer holds a cell ready to send |
| slot_tick | input | 1 | A transmit slot must be filled this cycle |
| slot_valid | output | 1 | The slot choice on `slot_sel` is new |
| slot_sel | output | 2 | Slot content: 00 empty, 01 buffered, 10 AIS |
| alarm_state | output | 1 | High while in the alarm state |

## Verification
The bench builds the block with `PERIOD` set to 3 instead of 1024. With that value the full insertion cycle is short: an AIS cell, three buffered cells with filler slots between them, then the next AIS cell. Counter reload and the case where the counter is cancelled by a regular arrival both fit in a few dozen cycles. The control logic is the same at every `PERIOD`, and only the counter width changes. So the same-cycle arrival and slot case, the reset taken in the middle of an alarm, and the unused class code are all reached at the same scale.

// File: rtl/ais_cell_steer.sv
module ais_cell_steer #(
  parameter int PERIOD = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [1:0] in_kind,
  input  logic       buf_ready,
  input  logic       slot_tick,
  output logic       slot_valid,
  output logic [1:0] slot_sel,
  output logic       alarm_state
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD);
  localparam logic [1:0] K_REG = 2'b00, K_AIS = 2'b10;
  localparam logic [1:0] S_EMPTY = 2'b00, S_BUF = 2'b01, S_AIS = 2'b10;

  logic [CW-1:0] cnt;
  logic          pend;

  wire got_ais = in_valid && (in_kind == K_AIS);
  wire got_reg = in_valid && (in_kind == K_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_valid  <= 1'b0;
      slot_sel    <= S_EMPTY;
      alarm_state <= 1'b0;
      pend        <= 1'b0;
      cnt         <= '0;
    end else begin
      slot_valid <= slot_tick;
      if (slot_tick) begin
        if (pend) begin
          slot_sel <= S_AIS;
          pend     <= 1'b0;
          cnt      <= RELOAD;
        end else if (buf_ready) begin
          slot_sel <= S_BUF;
          if (alarm_state) begin
            cnt <= cnt - CW'(1);
            if (cnt == CW'(1)) pend <= 1'b1;
          end
        end else begin
          slot_sel <= S_EMPTY;
        end
      end
      if (got_ais) begin
        alarm_state <= 1'b1;
        pend        <= 1'b1;
        cnt         <= RELOAD;
      end else if (got_reg) begin
        alarm_state <= 1'b0;
        pend        <= 1'b0;
        cnt         <= '0;
      end
    end
  end

  // R2
  strobe_follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
    slot_valid |-> $past(slot_tick));
  // R2
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    slot_valid |-> (slot_sel != 2'b11));
  // R3
  buf_only_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_sel == S_BUF) |-> $past(buf_ready));
  // R4
  ais_entry_chk: assert property (@(posedge clk) disable iff (rst)
    got_ais |=> (alarm_state && pend));
  // R5
  ais_only_in_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_valid && slot_sel == S_AIS) |-> $past(alarm_state));
  // R7
  regular_exit_chk: assert property (@(posedge clk) disable iff (rst)
    got_reg |=> (!alarm_state && !pend));
  // R7
  pending_needs_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> alarm_state);
endmodule

// File: tb/test_ais_cell_steer.sv
module test_ais_cell_steer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 20;
  // {in_valid, in_kind[1:0], buf_ready, slot_tick, exp_valid, exp_sel[1:0], exp_alarm}
  localparam logic [8:0] VEC [N] = '{
    9'b0_00_0_1_1_00_0, // R3 empty filler
    9'b0_00_1_1_1_01_0, // R3 buffered
    9'b0_00_1_0_0_00_0, // R2 no tick
    9'b1_01_1_1_1_01_0, // R8 empty arrival ignored
    9'b1_10_1_0_0_00_1, // R4 enter alarm
    9'b0_00_1_1_1_10_1, // R4 R6 AIS beats buffer
    9'b0_00_1_1_1_01_1, // R5 cnt 2
    9'b0_00_0_1_1_00_1, // R5 filler not counted
    9'b0_00_1_1_1_01_1, // R5 cnt 1
    9'b1_01_1_1_1_01_1, // R5 R8 cnt 0
    9'b0_00_1_1_1_10_1, // R5 periodic AIS
    9'b0_00_1_1_1_01_1, // R5 cnt 2
    9'b1_00_1_0_0_00_0, // R7 regular exits
    9'b0_00_1_1_1_01_0, // R7
    9'b0_00_1_1_1_01_0, // R7
    9'b0_00_1_1_1_01_0, // R7 no leftover AIS
    9'b1_11_0_1_1_00_0, // R8 unused code ignored
    9'b1_10_1_1_1_01_1, // R9 slot uses prior state
    9'b0_00_0_1_1_10_1, // R4 AIS with empty buffer
    9'b0_00_0_1_1_00_1  // R5 filler in alarm
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, buf_ready = 1'b0, slot_tick = 1'b0;
  logic [1:0] in_kind = 2'b00;
  logic slot_valid, alarm_state;
  logic [1:0] slot_sel;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ais_cell_steer #(.PERIOD(3)) i_ais_cell_steer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .buf_ready(buf_ready), .slot_tick(slot_tick), .slot_valid(slot_valid),
    .slot_sel(slot_sel), .alarm_state(alarm_state));

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [1:0] k, input logic b, input logic t,
                      input logic ev, input logic [1:0] es, input logic ea, input string req);
    in_valid = iv; in_kind = k; buf_ready = b; slot_tick = t;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; slot_tick = 1'b0;
    check(req, {slot_valid, ev ? slot_sel : 2'b00, alarm_state},
               {ev, es, ea});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {slot_valid, 2'b00, alarm_state}, 4'b0000);
    rst = 1'b0;
    for (int i = 0; i < N; i++)
      step(VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2:1], VEC[i][0],
           "R2 R3 R4 R5 R6 R7 R8 R9 vector");
    // R1 reset in mid-alarm clears pending insertion
    step(1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00, 1'b1, "R4");
    rst = 1'b1;
    step(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, "R1");
    rst = 1'b0;
    step(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, "R1");
    // R7 regular arrival cancels a pending AIS
    step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R4");
    step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, "R7");
    step(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0, "R7");
    // R8 empty arrival in alarm keeps state
    step(1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R4");
    step(1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R8");
    step(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, "R6");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule